// File: doc/BRIEF.md
# Period-Match Timer with Buffered Access

This block is a 16-bit up-counter made of two byte-wide halves. Software reaches it over an 8-bit register bus. The low byte of the count can be read and written directly. The high byte sits behind a one-byte buffer, so software always moves the full 16-bit value as a consistent pair. Reading the low byte captures the live high byte into the buffer on the same edge. Writing the low byte loads both halves at once, with the high half taken from the buffer.

The counter advances on one of two sources. The first is an internal tick that fires once every `INT_DIV` clocks. The second is the rising edges of an external count input. External edges can pass through a synchronizer chain (synchronous counter), or they can be edge-detected directly without re-timing (asynchronous counter). A prescaler can divide the selected events by 1, 2, 4 or 8. A 16-bit period register sets the terminal count: an increment taken while the count equals the period returns the count to zero and sets a sticky interrupt flag. An external event pulse clears the count at any time.

The external edge detector is a two-state machine. In state `LVL_HIGH`, a low sample moves it to `LVL_LOW`. In state `LVL_LOW`, a high sample moves it back to `LVL_HIGH` and emits one count event on that transition. Reset enters `LVL_HIGH`.

Top module: `prd_timer16`

Register map (the address is `bus_addr`): 0 control, 1 count low byte, 2 high-byte buffer, 3 period low byte, 4 period high byte, 5 flag. The control byte holds run in bit 0, source select in bit 1 (0 internal, 1 external), resync in bit 2 (1 synchronized) and the prescale code in bits 4:3.

## Requirements
- R1: The count is 16 bits wide. The low byte carries into the high byte. Each increment event adds exactly one unless a period match applies.
- R2: A read of address 1 returns the live count low byte, and on that edge copies the count high byte into the buffer. A read of address 2 returns the buffer.
- R3: A write to address 2 changes only the buffer. A write to address 1 loads the count with {buffer, data} on one edge and clears the prescaler.
- R4: With control bit 1 = 0, the source is an internal tick once every `INT_DIV` (default 4) clocks. With bit 1 = 1, the source is rising edges of `ext_in`.
- R5: Prescale code N in control bits 4:3 gives one increment per 2^N source events.
- R6: An increment taken while the count equals the period sets the count to 0000h and sets the flag. The period resets to FFFFh. A count above the period runs through FFFFh to 0000h without setting the flag.
- R7: The flag stays set until a write to address 5 loads bit 0 of the data into it. A set caused by a wrap wins over a clear on the same edge. A period of 0000h sets the flag on every increment, and the count stays at 0000h.
- R8: With control bit 2 = 1, `ext_in` passes a two-stage synchronizer, and a rise counts on the third clock edge that sees it high. With bit 2 = 0, the rise counts on the first such edge.
- R9: With control bit 0 = 0, source events are ignored and the count holds.
- R10: An `evt_reset` pulse clears the count and the prescaler. A count write on the same edge takes priority over the clear.
- R11: After reset, control, count and buffer are 00h, the period is FFFFh and the flag is 0. Addresses 6 and 7 read 00h.
- R12: An external level held high yields exactly one count. Each new rise yields one more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on address 1) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| ext_in | input | 1 | External count input |
| evt_reset | input | 1 | Event pulse that clears the count |
| irq_flag | output | 1 | Sticky period-match flag |

## Verification
The counter is driven from the internal tick at prescale 1:1 and 1:8, and from external pulse trains at 1:1 and 1:2. Fixed read spacings separate a wrong tick rate from a wrong prescale ratio. Single external rises with and without resync are sampled cycle by cycle, which exposes the two-cycle synchronizer latency, and a level held high shows that counting is edge-based rather than level-based. The period is exercised in three settings: an ordinary value, 0000h, and a value below a preloaded count that must roll through FFFFh without the flag. Buffered loads, reads and event clears with and without a same-edge write separate the byte-pairing rules from the clear priority.

// File: rtl/prd_timer16_pkg.sv
package prd_timer16_pkg;

    localparam int BYTE_W  = 8;
    localparam int N_BYTES = 2;
    localparam int CNT_W   = BYTE_W * N_BYTES;
    localparam int ADDR_W  = 3;
    localparam int PSEL_W  = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CNT_HB = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_PER_LO = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_PER_HI = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_FLAG   = 3'd5;

    typedef struct packed {
        logic [PSEL_W-1:0] psel;     // bits 4:3
        logic              resync;   // bit 2
        logic              use_ext;  // bit 1
        logic              run;      // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

endpackage

// File: rtl/prd_tick_src.sv
module prd_tick_src
    import prd_timer16_pkg::*;
#(
    parameter int INT_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic use_ext,
    input  logic resync,
    output logic src_evt
);

    localparam int PH_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(INT_DIV - 1);

    // internal instruction-rate tick
    logic [PH_W-1:0] ph_q;
    logic            int_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (ph_q == PH_LAST) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign int_tick = (ph_q == PH_LAST);

    // synchronizer chain, preset high so reset never fakes a rise
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            logic stage_q;
            if (g == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q <= 1'b1;
                    else        stage_q <= ext_in;
                end
            end else begin : g_tail
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q <= 1'b1;
                    else        stage_q <= g_sync[g-1].stage_q;
                end
            end
        end
    endgenerate

    logic sample;
    assign sample = resync ? g_sync[SYNC_STAGES-1].stage_q : ext_in;

    // edge detector state machine
    lvl_e lvl_q;
    lvl_e lvl_d;
    logic ext_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= LVL_HIGH;
        else        lvl_q <= lvl_d;
    end

    always_comb begin
        lvl_d    = lvl_q;
        ext_rise = 1'b0;
        unique case (lvl_q)
            LVL_LOW: begin
                if (sample) begin
                    lvl_d    = LVL_HIGH;
                    ext_rise = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!sample) lvl_d = LVL_LOW;
            end
        endcase
    end

    assign src_evt = use_ext ? ext_rise : int_tick;

endmodule

// File: rtl/prd_prescaler.sv
module prd_prescaler #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            src_evt,
    input  logic            clr,
    input  logic [PS_W-1:0] psel,
    output logic            step
);

    localparam int PC_W = (1 << PS_W) - 1;

    logic [PC_W-1:0] pre_q;
    logic [PC_W-1:0] term;

    // terminal value 2^psel - 1
    assign term = ~({PC_W{1'b1}} << psel);
    assign step = run & src_evt & (pre_q == term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (run && src_evt) begin
            pre_q <= step ? '0 : pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/prd_count_core.sv
module prd_count_core #(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [BYTE_W*N_BYTES-1:0]   load_val,
    input  logic                        clr,
    input  logic                        step,
    input  logic [BYTE_W*N_BYTES-1:0]   period,
    output logic [BYTE_W*N_BYTES-1:0]   cnt_q,
    output logic                        wrap
);

    localparam int CNT_W = BYTE_W * N_BYTES;

    logic [N_BYTES-1:0] carry;
    logic [CNT_W-1:0]   cnt_inc;
    logic               hit;

    assign carry[0] = 1'b1;

    // byte-wise ripple: each byte rolls FFh -> 00h and feeds the next
    genvar b;
    generate
        for (b = 0; b < N_BYTES; b++) begin : g_byte
            assign cnt_inc[b*BYTE_W +: BYTE_W] =
                cnt_q[b*BYTE_W +: BYTE_W] + BYTE_W'(carry[b]);
            if (b < N_BYTES - 1) begin : g_carry
                assign carry[b+1] = carry[b] & (&cnt_q[b*BYTE_W +: BYTE_W]);
            end
        end
    endgenerate

    assign hit  = (cnt_q == period);
    assign wrap = step & ~load & ~clr & hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= hit ? '0 : cnt_inc;
        end
    end

endmodule

// File: rtl/prd_timer16.sv
module prd_timer16
    import prd_timer16_pkg::*;
#(
    parameter int INT_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_in,
    input  logic              evt_reset,
    output logic              irq_flag
);

    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  per_q;
    logic [BYTE_W-1:0] hbuf_q;
    logic              flag_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              src_evt;
    logic              inc_evt;
    logic              wrap;
    logic              run_en;

    logic wr_ctrl, wr_lo, wr_hb, wr_plo, wr_phi, wr_flag, rd_lo;

    assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
    assign wr_lo   = bus_wr && (bus_addr == ADR_CNT_LO);
    assign wr_hb   = bus_wr && (bus_addr == ADR_CNT_HB);
    assign wr_plo  = bus_wr && (bus_addr == ADR_PER_LO);
    assign wr_phi  = bus_wr && (bus_addr == ADR_PER_HI);
    assign wr_flag = bus_wr && (bus_addr == ADR_FLAG);
    assign rd_lo   = bus_rd && (bus_addr == ADR_CNT_LO);
    assign run_en  = ctrl_q.run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            per_q  <= '1;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_plo)  per_q[0 +: BYTE_W]      <= bus_wdata;
            if (wr_phi)  per_q[BYTE_W +: BYTE_W] <= bus_wdata;
        end
    end

    // high-byte buffer: written by software, or snapshot on low-byte read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hbuf_q <= '0;
        end else if (wr_hb) begin
            hbuf_q <= bus_wdata;
        end else if (rd_lo) begin
            hbuf_q <= cnt_q[BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wrap) begin
            flag_q <= 1'b1;
        end else if (wr_flag) begin
            flag_q <= bus_wdata[0];
        end
    end

    assign irq_flag = flag_q;

    always_comb begin
        case (bus_addr)
            ADR_CTRL:   bus_rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
            ADR_CNT_LO: bus_rdata = cnt_q[0 +: BYTE_W];
            ADR_CNT_HB: bus_rdata = hbuf_q;
            ADR_PER_LO: bus_rdata = per_q[0 +: BYTE_W];
            ADR_PER_HI: bus_rdata = per_q[BYTE_W +: BYTE_W];
            ADR_FLAG:   bus_rdata = {{(BYTE_W-1){1'b0}}, flag_q};
            default:    bus_rdata = '0;
        endcase
    end

    prd_tick_src #(
        .INT_DIV     (INT_DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_in  (ext_in),
        .use_ext (ctrl_q.use_ext),
        .resync  (ctrl_q.resync),
        .src_evt (src_evt)
    );

    prd_prescaler #(
        .PS_W (PSEL_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_en),
        .src_evt (src_evt),
        .clr     (wr_lo | evt_reset),
        .psel    (ctrl_q.psel),
        .step    (inc_evt)
    );

    prd_count_core #(
        .BYTE_W  (BYTE_W),
        .N_BYTES (N_BYTES)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_lo),
        .load_val ({hbuf_q, bus_wdata}),
        .clr      (evt_reset),
        .step     (inc_evt),
        .period   (per_q),
        .cnt_q    (cnt_q),
        .wrap     (wrap)
    );

endmodule

// File: rtl/prd_timer16_chk.sv
module prd_timer16_chk
    import prd_timer16_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              evt_reset,
    input logic              irq_flag,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  per_q,
    input logic [BYTE_W-1:0] hbuf_q,
    input logic              inc_evt,
    input logic              run_en
);

    logic c_wr_lo, c_wr_hb, c_wr_flag, c_rd_lo;
    assign c_wr_lo   = bus_wr && (bus_addr == ADR_CNT_LO);
    assign c_wr_hb   = bus_wr && (bus_addr == ADR_CNT_HB);
    assign c_wr_flag = bus_wr && (bus_addr == ADR_FLAG);
    assign c_rd_lo   = bus_rd && (bus_addr == ADR_CNT_LO);

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_evt && !c_wr_lo && !evt_reset && cnt_q != per_q) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R1

    AST_READ_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd_lo && !c_wr_hb) |=> hbuf_q == $past(cnt_q[CNT_W-1 -: BYTE_W])); // R2

    AST_PAIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr_lo |=> cnt_q == {$past(hbuf_q), $past(bus_wdata)}); // R3

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_rd_lo && !c_wr_hb) |=> $stable(hbuf_q)); // R3

    AST_MATCH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_evt && !c_wr_lo && !evt_reset && cnt_q == per_q) |=> (cnt_q == '0 && irq_flag)); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !c_wr_flag) |=> irq_flag); // R7

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !c_wr_lo && !evt_reset) |=> $stable(cnt_q)); // R9

    AST_EVT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_reset && !c_wr_lo) |=> cnt_q == '0); // R10

endmodule

bind prd_timer16 prd_timer16_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_reset (evt_reset),
    .irq_flag  (irq_flag),
    .cnt_q     (cnt_q),
    .per_q     (per_q),
    .hbuf_q    (hbuf_q),
    .inc_evt   (inc_evt),
    .run_en    (run_en)
);

// File: tb/prd_timer16_tb.sv
module prd_timer16_tb;

    localparam int INT_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic       ext_in = 1'b0;
    logic       evt_reset = 1'b0;
    wire  [7:0] bus_rdata;
    wire        irq_flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    prd_timer16 #(.INT_DIV(INT_DIV), .SYNC_STAGES(2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_in    (ext_in),
        .evt_reset (evt_reset),
        .irq_flag  (irq_flag)
    );

    // ---------------- behavioural reference model ----------------
    int        m_ph;
    int        m_pre;
    bit        m_s1, m_s2, m_lvl;
    bit [15:0] m_cnt, m_per;
    bit [7:0]  m_hb;
    bit [4:0]  m_ctrl;
    bit        m_flag;

    always @(posedge clk) begin
        bit tick, samp, erise, src, inc, wlo, wrapped;
        bit [7:0] nhb;
        int div;
        if (!rst_n) begin
            m_ph = 0; m_pre = 0; m_s1 = 1; m_s2 = 1; m_lvl = 1;
            m_cnt = 0; m_per = 16'hFFFF; m_hb = 0; m_ctrl = 0; m_flag = 0;
        end else begin
            tick  = (m_ph == INT_DIV - 1);
            samp  = m_ctrl[2] ? m_s2 : ext_in;
            erise = !m_lvl && samp;
            src   = m_ctrl[1] ? erise : tick;
            div   = 1 << m_ctrl[4:3];
            inc   = m_ctrl[0] && src && (m_pre == div - 1);
            wlo   = bus_wr && bus_addr == 3'd1;
            if (bus_wr && bus_addr == 3'd2)      nhb = bus_wdata;
            else if (bus_rd && bus_addr == 3'd1) nhb = m_cnt[15:8];
            else                                 nhb = m_hb;
            m_ph  = tick ? 0 : m_ph + 1;
            m_s2  = m_s1; m_s1 = ext_in; m_lvl = samp;
            if (wlo || evt_reset)           m_pre = 0;
            else if (m_ctrl[0] && src)      m_pre = inc ? 0 : (m_pre + 1) % 8;
            wrapped = 0;
            if (wlo)            m_cnt = {m_hb, bus_wdata};
            else if (evt_reset) m_cnt = 0;
            else if (inc) begin
                if (m_cnt == m_per) begin m_cnt = 0; wrapped = 1; end
                else m_cnt = m_cnt + 16'd1;
            end
            m_hb = nhb;
            if (bus_wr && bus_addr == 3'd0) m_ctrl = bus_wdata[4:0];
            if (bus_wr && bus_addr == 3'd3) m_per[7:0]  = bus_wdata;
            if (bus_wr && bus_addr == 3'd4) m_per[15:8] = bus_wdata;
            if (wrapped) m_flag = 1;
            else if (bus_wr && bus_addr == 3'd5) m_flag = bus_wdata[0];
        end
    end

    function automatic bit [7:0] m_rd(input bit [2:0] a);
        case (a)
            3'd0: return {3'b000, m_ctrl};
            3'd1: return m_cnt[7:0];
            3'd2: return m_hb;
            3'd3: return m_per[7:0];
            3'd4: return m_per[15:8];
            3'd5: return {7'd0, m_flag};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input bit [2:0] a);
        case (a)
            3'd0: return "R9";
            3'd1: return "R1";
            3'd2: return "R2";
            3'd3, 3'd4: return "R6";
            3'd5: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tag_of(bus_addr), bus_rdata, m_rd(bus_addr));
            chk("R7", {7'd0, irq_flag}, {7'd0, m_flag});
        end
    end

    // ---------------- bus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(posedge clk); #2;
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #2;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2 ext_in = 1'b1;
            repeat (4) @(posedge clk);
            #2 ext_in = 1'b0;
            repeat (4) @(posedge clk);
        end
        #2;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d, a;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R11 reset values
        rd(3'd0, d); chk("R11", d, 8'h00);
        rd(3'd1, d); chk("R11", d, 8'h00);
        rd(3'd2, d); chk("R11", d, 8'h00);
        rd(3'd3, d); chk("R11", d, 8'hFF);
        rd(3'd4, d); chk("R11", d, 8'hFF);
        rd(3'd5, d); chk("R11", d, 8'h00);
        rd(3'd6, d); chk("R11", d, 8'h00);
        rd(3'd7, d); chk("R11", d, 8'h00);

        // R2/R3 buffered pair access (stopped)
        wr(3'd2, 8'h12); wr(3'd1, 8'h34);
        rd(3'd1, d); chk("R3", d, 8'h34);
        rd(3'd2, d); chk("R2", d, 8'h12);
        wr(3'd2, 8'h77);
        rd(3'd2, d); chk("R3", d, 8'h77);
        rd(3'd1, d); chk("R3", d, 8'h34);
        rd(3'd2, d); chk("R2", d, 8'h12);

        // R4 internal tick rate, 1:1: 40 clocks -> 10 increments
        wr(3'd2, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h01);
        rd(3'd1, a); idle(38); rd(3'd1, d);
        chk("R4", d, a + 8'd10);

        // R5 internal 1:8: 64 clocks -> 2 increments
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h19);
        rd(3'd1, a); idle(62); rd(3'd1, d);
        chk("R5", d, a + 8'd2);

        // R6 period match with carry into high byte
        wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd1, 8'hFA);
        wr(3'd3, 8'h05); wr(3'd4, 8'h01); wr(3'd0, 8'h01);
        idle(60);
        chk("R6", {7'd0, irq_flag}, 8'h01);
        wr(3'd0, 8'h00);
        rd(3'd1, d); chk("R6", d, m_cnt[7:0]);
        rd(3'd2, d); chk("R6", d, m_cnt[15:8]);

        // R7 clear flag by write of 0
        wr(3'd5, 8'h00);
        chk("R7", {7'd0, irq_flag}, 8'h00);

        // R6 above-period roll through FFFF without flag
        wr(3'd3, 8'h10); wr(3'd4, 8'h00);
        wr(3'd2, 8'hFF); wr(3'd1, 8'hFE); wr(3'd0, 8'h01);
        idle(10); wr(3'd0, 8'h00);
        chk("R6", {7'd0, irq_flag}, 8'h00);
        rd(3'd1, d); rd(3'd2, d); chk("R6", d, 8'h00);

        // R7 period 0000h: flag on every increment, count stays zero
        wr(3'd3, 8'h00); wr(3'd4, 8'h00);
        wr(3'd2, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h01);
        idle(10); wr(3'd0, 8'h00);
        chk("R7", {7'd0, irq_flag}, 8'h01);
        rd(3'd1, d); chk("R7", d, 8'h00);
        wr(3'd5, 8'h00);
        wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);

        // R8 synchronized latency: counted on the third edge
        wr(3'd1, 8'h00); wr(3'd0, 8'h07);
        @(posedge clk); #2 bus_addr = 3'd1; ext_in = 1'b1;
        @(posedge clk); #2 chk("R8", bus_rdata, 8'h00);
        @(posedge clk); #2 chk("R8", bus_rdata, 8'h00);
        @(posedge clk); #2 chk("R8", bus_rdata, 8'h01);
        ext_in = 1'b0; idle(4);

        // R8 synchronized pulse train
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h07);
        pulses(5);
        rd(3'd1, d); chk("R8", d, 8'h05);

        // R8 raw edge: counted on the first edge
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h03);
        @(posedge clk); #2 bus_addr = 3'd1; ext_in = 1'b1;
        @(posedge clk); #2 chk("R8", bus_rdata, 8'h01);
        // R12 level held high counts once
        idle(20); chk("R12", bus_rdata, 8'h01);
        ext_in = 1'b0; idle(5);
        ext_in = 1'b1; idle(5);
        chk("R12", bus_rdata, 8'h02);
        ext_in = 1'b0; idle(3);

        // R5 external 1:2: 4 pulses -> 2
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h0B);
        pulses(4);
        rd(3'd1, d); chk("R5", d, 8'h02);
        // R4 external selection counts edges not ticks
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h03);
        idle(40);
        rd(3'd1, d); chk("R4", d, 8'h00);

        // R9 stopped: external edges ignored
        wr(3'd0, 8'h02); wr(3'd1, 8'h00);
        pulses(3);
        rd(3'd1, d); chk("R9", d, 8'h00);

        // R10 event clear
        wr(3'd2, 8'h12); wr(3'd1, 8'h34);
        @(posedge clk); #2 evt_reset = 1'b1;
        @(posedge clk); #2 evt_reset = 1'b0;
        rd(3'd1, d); chk("R10", d, 8'h00);
        rd(3'd2, d); chk("R10", d, 8'h00);
        // R10 write wins over same-edge clear
        wr(3'd2, 8'h21);
        @(posedge clk); #2;
        evt_reset = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h43;
        @(posedge clk); #2;
        evt_reset = 1'b0; bus_wr = 1'b0;
        rd(3'd1, d); chk("R10", d, 8'h43);
        rd(3'd2, d); chk("R10", d, 8'h21);

        idle(4);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule